// File: doc/BRIEF.md
# Non-Maskable Interrupt Edge Latch and Entry Sequencer

This block handles the processor side of a non-maskable interrupt for an 8-bit core with a 16-bit address space. It watches an active-low interrupt line and remembers a high-to-low transition in a pending flag. A held-low line produces one request only. Nothing inside the core can mask the request. When the core reports an instruction boundary while the flag is set, the block takes over the memory bus. It saves the return address and the status byte on the stack in page one, then loads the handler address from the fixed vector pair at $FFFA (low) and $FFFB (high).

At the end of the sequence the block raises a one-cycle completion pulse. In the same cycle it presents the handler address and the stack pointer after the three pushes. The core loads both and continues at the handler. The pending flag is cleared when the sequence is accepted. A new falling edge that arrives while the sequence runs is therefore kept, and it is serviced once the current entry has finished.

The memory port is synchronous. Read data returns on the cycle after the read strobe.

Top module: `nmi_entry_unit`

## Requirements
- R1: A falling edge on `nmi_n` (high at one rising clock edge, low at the next) sets the pending flag at the second of those clock edges.
- R2: While `nmi_n` stays low, no further request is latched. The line must go high and fall again before another entry can occur.
- R3: An entry is accepted only at a clock edge where the block is idle, `insn_boundary` is high and the pending flag is already set. The first bus cycle of the entry is the cycle after that edge. A boundary strobe while busy or while nothing is pending has no effect.
- R4: The value on `cur_status` never blocks or delays an entry. An all-ones status is serviced like any other value.
- R5: The three bus cycles after acceptance are writes (`bus_we`=1) of, in order, the high byte of `cur_pc`, the low byte of `cur_pc`, and `cur_status`. Each goes to address {8'h01, SP}, where SP starts at `cur_sp` and drops by one after each write, wrapping from 8'h00 to 8'hFF inside page one.
- R6: The next two cycles are reads (`bus_rd`=1, `bus_we`=0) from 16'hFFFA and then 16'hFFFB. The data for each read arrives on `bus_rdata` one cycle later. A write and a read are never requested together.
- R7: Seven cycles after the accepting edge, `done` is high for exactly one cycle. In that cycle `vector_pc` = {byte read from $FFFB, byte read from $FFFA} and `stack_ptr` = `cur_sp` − 3 (mod 256).
- R8: The pending flag is cleared when an entry is accepted. A falling edge that arrives at the accepting edge or at any point during the sequence is latched, and it starts a second entry as soon as the block is idle with the boundary strobe high.
- R9: `busy` is high for exactly the six cycles from the first push through the cycle after the second vector read, and low otherwise, including the `done` cycle.
- R10: Synchronous active-high reset clears the pending flag and returns the block to idle. A line that is already low when reset is released does not count as a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_n | input | 1 | Active-low non-maskable interrupt line |
| insn_boundary | input | 1 | High in cycles where the core may start an interrupt entry |
| cur_pc | input | 16 | Return address to save |
| cur_status | input | 8 | Status byte to save |
| cur_sp | input | 8 | Stack pointer before the entry |
| bus_addr | output | 16 | Memory address |
| bus_wdata | output | 8 | Write data |
| bus_we | output | 1 | Write enable |
| bus_rd | output | 1 | Read strobe, data returns next cycle |
| bus_rdata | input | 8 | Read data |
| busy | output | 1 | Entry sequence owns the bus |
| done | output | 1 | One-cycle completion pulse |
| vector_pc | output | 16 | Handler address, valid with `done` |
| stack_ptr | output | 8 | Stack pointer after the pushes, valid with `done` |

## Verification
The bench targets a falling edge that coincides with the accepting edge. A design that clears the flag at completion, or lets the clear win, would drop the second interrupt. A second edge during the sequence, with the boundary strobe held high, exposes designs that restart early or lose the request. A line held low across several boundaries would show a level-sensitive latch as repeated entries. A stack pointer of 8'h01 forces a wrap inside page one, which catches a borrow into the page byte. Changing vector bytes between entries catches swapped halves or a read sampled one cycle too early.

// File: rtl/nmi_entry_pkg.sv
package nmi_entry_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] DEF_STACK_PAGE = 8'h01;
    localparam logic [ADDR_W-1:0] DEF_VECTOR_LO  = 16'hFFFA;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PUSH_PCH = 3'd1,
        ST_PUSH_PCL = 3'd2,
        ST_PUSH_PSR = 3'd3,
        ST_VEC_LO   = 3'd4,
        ST_VEC_HI   = 3'd5,
        ST_VEC_CAP  = 3'd6
    } seq_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] psr;
        logic [DATA_W-1:0] sp;
    } entry_ctx_t;

    typedef struct packed {
        logic              we;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic is_push(input seq_state_t st);
        return (st == ST_PUSH_PCH) || (st == ST_PUSH_PCL) || (st == ST_PUSH_PSR);
    endfunction

    function automatic logic [DATA_W-1:0] push_byte(input seq_state_t st,
                                                    input entry_ctx_t ctx);
        case (st)
            ST_PUSH_PCH: return ctx.pc[ADDR_W-1:DATA_W];
            ST_PUSH_PCL: return ctx.pc[DATA_W-1:0];
            default:     return ctx.psr;
        endcase
    endfunction

    function automatic seq_state_t step_state(input seq_state_t st);
        case (st)
            ST_PUSH_PCH: return ST_PUSH_PCL;
            ST_PUSH_PCL: return ST_PUSH_PSR;
            ST_PUSH_PSR: return ST_VEC_LO;
            ST_VEC_LO:   return ST_VEC_HI;
            ST_VEC_HI:   return ST_VEC_CAP;
            default:     return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_n_i,
    input  logic take_i,
    output logic pending_o
);
    logic line_q;
    logic pend_q;
    logic fall;

    assign fall      = line_q & ~nmi_n_i;
    assign pending_o = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= nmi_n_i;
            pend_q <= 1'b0;
        end else begin
            line_q <= nmi_n_i;
            pend_q <= fall | (pend_q & ~take_i);
        end
    end

    // R1
    fall_sets_pending_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(nmi_n_i) |=> pend_q);

    // R2
    held_low_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!pend_q && !nmi_n_i && !$past(nmi_n_i)) |=> !pend_q);

    // R8
    pending_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (take_i && nmi_n_i) |=> !pend_q);

endmodule

// File: rtl/nmi_entry_seq.sv
module nmi_entry_seq
    import nmi_entry_pkg::*;
#(
    parameter logic [DATA_W-1:0] STACK_PAGE = DEF_STACK_PAGE,
    parameter logic [ADDR_W-1:0] VECTOR_LO  = DEF_VECTOR_LO
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary_i,
    input  logic              pending_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] psr_i,
    input  logic [DATA_W-1:0] sp_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              take_o,
    output logic              busy_o,
    output bus_req_t          req_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] new_pc_o,
    output logic [DATA_W-1:0] sp_o
);
    localparam logic [ADDR_W-1:0] VECTOR_HI = VECTOR_LO + 16'd1;

    seq_state_t        state_q;
    entry_ctx_t        ctx_q;
    logic [DATA_W-1:0] lo_q;
    logic [ADDR_W-1:0] npc_q;
    logic              done_q;

    assign take_o   = (state_q == ST_IDLE) && boundary_i && pending_i;
    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = done_q;
    assign new_pc_o = npc_q;
    assign sp_o     = ctx_q.sp;

    always_comb begin
        req_o = '0;
        if (is_push(state_q)) begin
            req_o.we    = 1'b1;
            req_o.addr  = {STACK_PAGE, ctx_q.sp};
            req_o.wdata = push_byte(state_q, ctx_q);
        end else if (state_q == ST_VEC_LO) begin
            req_o.rd   = 1'b1;
            req_o.addr = VECTOR_LO;
        end else if (state_q == ST_VEC_HI) begin
            req_o.rd   = 1'b1;
            req_o.addr = VECTOR_HI;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctx_q   <= '0;
            lo_q    <= '0;
            npc_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (take_o) begin
                        ctx_q.pc  <= pc_i;
                        ctx_q.psr <= psr_i;
                        ctx_q.sp  <= sp_i;
                        state_q   <= ST_PUSH_PCH;
                    end
                end
                ST_PUSH_PCH, ST_PUSH_PCL, ST_PUSH_PSR: begin
                    ctx_q.sp <= ctx_q.sp - 8'd1;
                    state_q  <= step_state(state_q);
                end
                ST_VEC_LO: begin
                    state_q <= step_state(state_q);
                end
                ST_VEC_HI: begin
                    lo_q    <= rdata_i;
                    state_q <= step_state(state_q);
                end
                ST_VEC_CAP: begin
                    npc_q   <= {rdata_i, lo_q};
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R3
    start_gated_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(boundary_i && pending_i));

    // R5
    stack_page_chk: assert property (@(posedge clk) disable iff (rst)
        req_o.we |-> (req_o.addr[ADDR_W-1:DATA_W] == STACK_PAGE));

    // R6
    we_rd_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_o.we && req_o.rd));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(busy_o) && !busy_o));

endmodule

// File: rtl/nmi_entry_unit.sv
module nmi_entry_unit
    import nmi_entry_pkg::*;
#(
    parameter logic [DATA_W-1:0] STACK_PAGE = DEF_STACK_PAGE,
    parameter logic [ADDR_W-1:0] VECTOR_LO  = DEF_VECTOR_LO
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi_n,
    input  logic              insn_boundary,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [DATA_W-1:0] cur_status,
    input  logic [DATA_W-1:0] cur_sp,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_rd,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] vector_pc,
    output logic [DATA_W-1:0] stack_ptr
);
    logic     pending;
    logic     take;
    bus_req_t req;

    nmi_edge_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .nmi_n_i   (nmi_n),
        .take_i    (take),
        .pending_o (pending)
    );

    nmi_entry_seq #(
        .STACK_PAGE (STACK_PAGE),
        .VECTOR_LO  (VECTOR_LO)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .boundary_i (insn_boundary),
        .pending_i  (pending),
        .pc_i       (cur_pc),
        .psr_i      (cur_status),
        .sp_i       (cur_sp),
        .rdata_i    (bus_rdata),
        .take_o     (take),
        .busy_o     (busy),
        .req_o      (req),
        .done_o     (done),
        .new_pc_o   (vector_pc),
        .sp_o       (stack_ptr)
    );

    assign bus_addr  = req.addr;
    assign bus_wdata = req.wdata;
    assign bus_we    = req.we;
    assign bus_rd    = req.rd;

endmodule

// File: tb/nmi_entry_unit_bench.sv
`timescale 1ns/1ps
module nmi_entry_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_n = 1'b0;
    logic        insn_boundary = 1'b0;
    logic [15:0] cur_pc = 16'h1234;
    logic [7:0]  cur_status = 8'h24;
    logic [7:0]  cur_sp = 8'hFD;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_we, bus_rd, busy, done;
    logic [7:0]  bus_rdata;
    logic [15:0] vector_pc;
    logic [7:0]  stack_ptr;

    always #2 clk = ~clk;

    nmi_entry_unit u_nmi_entry_unit (
        .clk(clk), .rst(rst), .nmi_n(nmi_n), .insn_boundary(insn_boundary),
        .cur_pc(cur_pc), .cur_status(cur_status), .cur_sp(cur_sp),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .busy(busy), .done(done),
        .vector_pc(vector_pc), .stack_ptr(stack_ptr)
    );

    // behavioural memory: page-one stack plus the two vector bytes
    logic [7:0] stack_mem [256];
    logic [7:0] vlo = 8'h80;
    logic [7:0] vhi = 8'hC0;

    always @(posedge clk) begin
        if (bus_we) stack_mem[bus_addr[7:0]] <= bus_wdata;
        if (bus_rd)
            bus_rdata <= (bus_addr == 16'hFFFA) ? vlo :
                         (bus_addr == 16'hFFFB) ? vhi : stack_mem[bus_addr[7:0]];
    end

    int checks = 0;
    int failures = 0;
    int dones = 0;
    bit finished = 0;

    typedef struct {
        bit          busy, we, rd, done;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [15:0] npc;
        logic [7:0]  sp;
    } exp_t;

    exp_t expq[$];
    bit   m_prev, m_pend;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic exp_t mk(bit b, bit w, bit r, bit d, logic [15:0] a,
                                logic [7:0] wd, logic [15:0] np, logic [7:0] s);
        exp_t e;
        e.busy = b; e.we = w; e.rd = r; e.done = d;
        e.addr = a; e.wdata = wd; e.npc = np; e.sp = s;
        return e;
    endfunction

    task automatic model_edge();
        exp_t p;
        bit idle, acc, fall;
        logic [7:0] s;
        if (rst) begin
            expq.delete();
            m_prev = nmi_n;
            m_pend = 0;
            return;
        end
        idle = 1;
        if (expq.size() > 0) begin
            p = expq.pop_front();
            idle = !p.busy;
        end
        acc  = idle && insn_boundary && m_pend;
        fall = m_prev && !nmi_n;
        m_pend = fall || (m_pend && !acc);
        m_prev = nmi_n;
        if (acc) begin
            s = cur_sp;
            expq.push_back(mk(1, 1, 0, 0, {8'h01, s},         cur_pc[15:8], 0, 0));
            expq.push_back(mk(1, 1, 0, 0, {8'h01, s - 8'd1},  cur_pc[7:0],  0, 0));
            expq.push_back(mk(1, 1, 0, 0, {8'h01, s - 8'd2},  cur_status,   0, 0));
            expq.push_back(mk(1, 0, 1, 0, 16'hFFFA, 0, 0, 0));
            expq.push_back(mk(1, 0, 1, 0, 16'hFFFB, 0, 0, 0));
            expq.push_back(mk(1, 0, 0, 0, 0, 0, 0, 0));
            expq.push_back(mk(0, 0, 0, 1, 0, 0, {vhi, vlo}, s - 8'd3));
        end
    endtask

    task automatic compare();
        exp_t e;
        e = (expq.size() > 0) ? expq[0] : mk(0, 0, 0, 0, 0, 0, 0, 0);
        if (done) dones++;
        chk(busy == e.busy,   "R9", "busy",   busy,   e.busy);
        chk(bus_we == e.we,   "R5", "bus_we", bus_we, e.we);
        chk(bus_rd == e.rd,   "R6", "bus_rd", bus_rd, e.rd);
        chk(done == e.done,   "R7", "done",   done,   e.done);
        if (e.we) begin
            chk(bus_addr == e.addr,   "R5", "push addr", bus_addr,  e.addr);
            chk(bus_wdata == e.wdata, "R5", "push data", bus_wdata, e.wdata);
        end
        if (e.rd)
            chk(bus_addr == e.addr, "R6", "vector addr", bus_addr, e.addr);
        if (e.done) begin
            chk(vector_pc == e.npc, "R7", "vector_pc", vector_pc, e.npc);
            chk(stack_ptr == e.sp,  "R7", "stack_ptr", stack_ptr, e.sp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        // reset with the line already low
        step(3);
        chk(busy == 0 && done == 0 && bus_we == 0 && bus_rd == 0, "R10",
            "idle in reset", {busy, done, bus_we, bus_rd}, 0);
        rst = 0;
        // R10: a low line at reset release is not an edge
        insn_boundary = 1;
        step(6);
        insn_boundary = 0;
        chk(dones == 0, "R10", "entries after reset", dones, 0);

        // R1 and R3: single edge, strobe arrives later
        nmi_n = 1; step(2);
        nmi_n = 0; step(3);
        chk(busy == 0, "R3", "no entry without strobe", busy, 0);
        insn_boundary = 1; step(1);
        insn_boundary = 0; step(10);
        chk(dones == 1, "R1", "entry count", dones, 1);
        chk(stack_mem[8'hFD] == 8'h12, "R5", "stack FD", stack_mem[8'hFD], 8'h12);
        chk(stack_mem[8'hFC] == 8'h34, "R5", "stack FC", stack_mem[8'hFC], 8'h34);
        chk(stack_mem[8'hFB] == 8'h24, "R5", "stack FB", stack_mem[8'hFB], 8'h24);

        // R2: line held low, repeated strobes
        insn_boundary = 1; step(12);
        insn_boundary = 0; step(1);
        chk(dones == 1, "R2", "held low gives no new entry", dones, 1);

        // R4 and stack wrap, new vector bytes
        nmi_n = 1; step(1);
        cur_pc = 16'hABCD; cur_status = 8'hFF; cur_sp = 8'h01;
        vlo = 8'h5A; vhi = 8'h9F;
        nmi_n = 0; step(1);
        insn_boundary = 1; step(1);
        insn_boundary = 0; step(10);
        chk(dones == 2, "R4", "all-ones status serviced", dones, 2);
        chk(stack_mem[8'h01] == 8'hAB, "R5", "stack 01", stack_mem[8'h01], 8'hAB);
        chk(stack_mem[8'h00] == 8'hCD, "R5", "stack 00", stack_mem[8'h00], 8'hCD);
        chk(stack_mem[8'hFF] == 8'hFF, "R5", "stack FF wrap", stack_mem[8'hFF], 8'hFF);

        // R8: second edge during the sequence, strobe held high
        cur_pc = 16'h4321; cur_status = 8'h00; cur_sp = 8'h80;
        nmi_n = 1; step(1);
        nmi_n = 0; insn_boundary = 1; step(3);
        nmi_n = 1; step(1);
        nmi_n = 0; step(14);
        insn_boundary = 0; step(3);
        chk(dones == 4, "R8", "edge during sequence serviced", dones, 4);

        // R8: edge on the accepting clock edge itself
        vlo = 8'h01; vhi = 8'h70;
        nmi_n = 1; step(1);
        nmi_n = 0; step(1);
        nmi_n = 1; step(1);
        nmi_n = 0; insn_boundary = 1; step(20);
        insn_boundary = 0; step(3);
        chk(dones == 6, "R8", "edge at acceptance kept", dones, 6);
        chk(busy == 0, "R9", "idle at end", busy, 0);

        finish_run();
    end

endmodule